// File: doc/BRIEF.md
# Byte-Wide Interrupt-Driven SPI Master

This peripheral exchanges one 8-bit word at a time with an SPI slave. Software programs a small register file over a byte-wide bus. The registers hold the clock polarity and phase, the SCK enable, the master enable, the interrupt mode, an idle-line option for MOSI and an 8-bit clock prescaler. A single write to the transmit register launches a full-duplex exchange. Eight SCK periods later the byte shifted in from MISO can be read from the receive register.

Completion sets a ready flag. When interrupt mode is on, the same flag drives the interrupt line. A transmit write that arrives while a byte is still moving is rejected and recorded in a sticky collision flag. Chip-select is produced outside the block.

Register offsets on `addr`:
- 0: control. Bit 0 is interrupt mode, bit 1 master enable, bit 2 SCK enable, bit 3 CPOL, bit 4 CPHA.
- 1: status. Bit 0 is ready, bit 1 collision, bit 2 busy.
- 2: pin control. Bit 0 is keep.
- 3: prescaler.
- 4: transmit data. Reads return 0.
- 5: receive data.

Top module: `byte_spi_master`

## Requirements
- R1: After reset the prescaler reads 0xFF and control, pin control, status and receive data read 0. After reset `sck` is 0, `irq` is 0 and `mosi_oe` is 0.
- R2: During a transfer each SCK half period lasts prescaler+1 clock cycles. A byte takes exactly 16 SCK edges, and SCK rests at the CPOL level (control bit 3) whenever no transfer runs.
- R3: With CPHA=0 (control bit 4 clear), MOSI holds the MSB before the first SCK edge and changes on trailing edges. MISO is sampled on leading edges. Data moves MSB first, and the received byte appears at offset 5.
- R4: With CPHA=1, MOSI changes on leading edges and MISO is sampled on trailing edges, MSB first.
- R5: With CPOL=1, SCK idles high and the exchange still completes correctly in both phases.
- R6: Completion sets status bit 0 (ready). `irq` is high after completion exactly when control bit 0 is set.
- R7: A status read clears ready and collision. If a status read falls in the same cycle that a byte completes, ready ends up set.
- R8: A transmit write while busy sets status bit 1 (collision). The written byte is discarded, and the ongoing byte finishes with its original data.
- R9: If SCK enable (bit 2) or master enable (bit 1) is clear, a transmit write starts nothing. SCK stays at CPOL and no status bit is set.
- R10: With keep (pin control bit 0) clear, `mosi_oe` is low between transfers. With keep set, `mosi_oe` stays high and `mosi` holds the last bit sent.
- R11: An accepted transmit write clears ready, so `irq` falls on the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Peripheral clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cs | input | 1 | Register access select |
| wr | input | 1 | Write strobe |
| rd | input | 1 | Read strobe; status reads have side effects |
| addr | input | 3 | Register offset |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data (combinational) |
| irq | output | 1 | Interrupt request |
| sck | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| mosi_oe | output | 1 | Output enable for MOSI |
| miso | input | 1 | Serial data in |

## Verification
Two things can fall in one cycle: a status read, which clears ready, and the final SCK edge of a byte, which sets it. With the prescaler at 0, the last edge lands a known 16 cycles after the transmit write. The bench times a status read onto exactly that cycle. The read must return busy with ready still clear. A second read must then find ready set, because completion outranks the clear.

A related case is a transmit write during an active byte. The bench checks that this write raises collision, while the slave still receives the first byte and the receive register holds the slave's reply.

// File: rtl/spi_pkg.sv
package spi_pkg;
   localparam int BUS_W  = 8;
   localparam int ADDR_W = 3;

   localparam logic [ADDR_W-1:0] OFS_CTRL = 3'd0;
   localparam logic [ADDR_W-1:0] OFS_STAT = 3'd1;
   localparam logic [ADDR_W-1:0] OFS_PIN  = 3'd2;
   localparam logic [ADDR_W-1:0] OFS_PRE  = 3'd3;
   localparam logic [ADDR_W-1:0] OFS_TX   = 3'd4;
   localparam logic [ADDR_W-1:0] OFS_RX   = 3'd5;

   // control register, bit 0 = irq_en ... bit 4 = cpha
   typedef struct packed {
      logic cpha;
      logic cpol;
      logic sck_en;
      logic master;
      logic irq_en;
   } ctrl_t;

   localparam int CTRL_W = $bits(ctrl_t);
endpackage

// File: rtl/spi_clk_div.sv
module spi_clk_div #(
   parameter int PRE_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run,
   input  logic [PRE_W-1:0] pre,
   output logic             tick
);
   logic [PRE_W-1:0] cnt;

   assign tick = run && (cnt == pre);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          cnt <= '0;
      else if (!run)       cnt <= '0;
      else if (cnt == pre) cnt <= '0;
      else                 cnt <= cnt + 1'b1;
   end
endmodule

// File: rtl/spi_shift_engine.sv
module spi_shift_engine #(
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic [DATA_W-1:0] tx_byte,
   input  logic              cpha,
   input  logic              tick,
   input  logic              miso,
   output logic              busy,
   output logic              done,
   output logic              phase,
   output logic              mosi_bit,
   output logic [DATA_W-1:0] rx_byte
);
   localparam int EDGES = 2 * DATA_W;
   localparam int EW    = $clog2(EDGES);
   localparam logic [EW-1:0] LAST = EW'(EDGES - 1);

   logic [EW-1:0]     edge_idx;
   logic [DATA_W-1:0] txsh, rxsh;
   logic              cpha_q;
   logic              leading, last_edge, do_shift, do_sample;

   assign leading   = ~edge_idx[0];
   assign last_edge = (edge_idx == LAST);
   assign done      = busy && tick && last_edge;
   assign do_shift  = cpha_q ? leading : (~leading && !last_edge);
   assign do_sample = cpha_q ? ~leading : leading;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy     <= 1'b0;
         edge_idx <= '0;
         phase    <= 1'b0;
         txsh     <= '0;
         rxsh     <= '0;
         cpha_q   <= 1'b0;
         mosi_bit <= 1'b0;
         rx_byte  <= '0;
      end else if (start) begin
         busy     <= 1'b1;
         edge_idx <= '0;
         phase    <= 1'b0;
         rxsh     <= '0;
         cpha_q   <= cpha;
         if (!cpha) begin
            mosi_bit <= tx_byte[DATA_W-1];
            txsh     <= {tx_byte[DATA_W-2:0], 1'b0};
         end else begin
            txsh     <= tx_byte;
         end
      end else if (busy && tick) begin
         phase    <= ~phase;
         edge_idx <= edge_idx + 1'b1;
         if (do_shift) begin
            mosi_bit <= txsh[DATA_W-1];
            txsh     <= {txsh[DATA_W-2:0], 1'b0};
         end
         if (do_sample) rxsh <= {rxsh[DATA_W-2:0], miso};
         if (last_edge) begin
            busy    <= 1'b0;
            rx_byte <= cpha_q ? {rxsh[DATA_W-2:0], miso} : rxsh;
         end
      end
   end
endmodule

// File: rtl/spi_regfile.sv
module spi_regfile
   import spi_pkg::*;
#(
   parameter int                PRE_W     = 8,
   parameter logic [PRE_W-1:0]  PRE_RESET = '1,
   parameter int                DATA_W    = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cs,
   input  logic              wr,
   input  logic              rd,
   input  logic [ADDR_W-1:0] addr,
   input  logic [BUS_W-1:0]  wdata,
   output logic [BUS_W-1:0]  rdata,
   input  logic              busy,
   input  logic              done,
   input  logic [DATA_W-1:0] rx_byte,
   output ctrl_t             ctrl,
   output logic              keep,
   output logic [PRE_W-1:0]  pre,
   output logic              tx_wr,
   output logic              stat_rd,
   output logic              start,
   output logic              may_run,
   output logic              ready,
   output logic              coll,
   output logic              irq
);
   assign tx_wr   = cs && wr && (addr == OFS_TX);
   assign stat_rd = cs && rd && (addr == OFS_STAT);
   assign may_run = ctrl.master && ctrl.sck_en;
   assign start   = tx_wr && !busy && may_run;
   assign irq     = ready && ctrl.irq_en;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctrl <= '0;
         keep <= 1'b0;
         pre  <= PRE_RESET;
      end else if (cs && wr) begin
         case (addr)
            OFS_CTRL: ctrl <= ctrl_t'(wdata[CTRL_W-1:0]);
            OFS_PIN:  keep <= wdata[0];
            OFS_PRE:  pre  <= wdata[PRE_W-1:0];
            default: ;
         endcase
      end
   end

   // completion outranks clearing
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                ready <= 1'b0;
      else if (done)             ready <= 1'b1;
      else if (stat_rd || start) ready <= 1'b0;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)             coll <= 1'b0;
      else if (tx_wr && busy) coll <= 1'b1;
      else if (stat_rd)       coll <= 1'b0;
   end

   always_comb begin
      rdata = '0;
      case (addr)
         OFS_CTRL: rdata = BUS_W'(ctrl);
         OFS_STAT: rdata = BUS_W'({busy, coll, ready});
         OFS_PIN:  rdata = BUS_W'(keep);
         OFS_PRE:  rdata = BUS_W'(pre);
         OFS_RX:   rdata = BUS_W'(rx_byte);
         default:  rdata = '0;
      endcase
   end
endmodule

// File: rtl/byte_spi_master.sv
module byte_spi_master
   import spi_pkg::*;
#(
   parameter int               DATA_W    = 8,
   parameter int               PRE_W     = 8,
   parameter logic [PRE_W-1:0] PRE_RESET = '1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cs,
   input  logic              wr,
   input  logic              rd,
   input  logic [ADDR_W-1:0] addr,
   input  logic [BUS_W-1:0]  wdata,
   output logic [BUS_W-1:0]  rdata,
   output logic              irq,
   output logic              sck,
   output logic              mosi,
   output logic              mosi_oe,
   input  logic              miso
);
   generate
      if (DATA_W != 8) begin : g_bad_word
         $error("byte_spi_master: word size must be 8");
      end
      if (PRE_W < 1 || PRE_W > BUS_W) begin : g_bad_pre
         $error("byte_spi_master: prescaler width out of range");
      end
   endgenerate

   ctrl_t             ctrl;
   logic              keep, tx_wr, stat_rd, start, may_run, ready, coll;
   logic              busy, done, phase, mosi_bit, tick;
   logic [PRE_W-1:0]  pre;
   logic [DATA_W-1:0] rx_byte;
   logic              cpol;

   assign cpol = ctrl.cpol;

   spi_regfile #(.PRE_W(PRE_W), .PRE_RESET(PRE_RESET), .DATA_W(DATA_W)) u_regs (
      .clk(clk), .rst_n(rst_n), .cs(cs), .wr(wr), .rd(rd), .addr(addr),
      .wdata(wdata), .rdata(rdata), .busy(busy), .done(done), .rx_byte(rx_byte),
      .ctrl(ctrl), .keep(keep), .pre(pre), .tx_wr(tx_wr), .stat_rd(stat_rd),
      .start(start), .may_run(may_run), .ready(ready), .coll(coll), .irq(irq)
   );

   spi_clk_div #(.PRE_W(PRE_W)) u_div (
      .clk(clk), .rst_n(rst_n), .run(busy), .pre(pre), .tick(tick)
   );

   spi_shift_engine #(.DATA_W(DATA_W)) u_eng (
      .clk(clk), .rst_n(rst_n), .start(start), .tx_byte(wdata[DATA_W-1:0]),
      .cpha(ctrl.cpha), .tick(tick), .miso(miso), .busy(busy), .done(done),
      .phase(phase), .mosi_bit(mosi_bit), .rx_byte(rx_byte)
   );

   assign sck     = busy ? (cpol ^ phase) : cpol;
   assign mosi    = mosi_bit;
   assign mosi_oe = busy || keep;
endmodule

// File: rtl/byte_spi_master_chk.sv
module byte_spi_master_chk (
   input logic clk,
   input logic rst_n,
   input logic busy,
   input logic done,
   input logic tick,
   input logic sck,
   input logic tx_wr,
   input logic stat_rd,
   input logic may_run,
   input logic ready,
   input logic coll,
   input logic irq,
   input logic irq_en
);
   // R2
   sck_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && $past(busy) && !$past(tick)) |-> $stable(sck));

   // R6
   ready_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ready) |-> $past(busy));

   // R6
   irq_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (done && irq_en) |=> irq);

   // R7
   stat_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (stat_rd && !done) |=> (!ready && !coll) || $past(tx_wr));

   // R8
   coll_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (tx_wr && busy && !done) |=> (coll && busy));

   // R9
   no_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (tx_wr && !busy && !may_run) |=> !busy);
endmodule

bind byte_spi_master byte_spi_master_chk u_chk (
   .clk(clk), .rst_n(rst_n), .busy(busy), .done(done), .tick(tick), .sck(sck),
   .tx_wr(tx_wr), .stat_rd(stat_rd), .may_run(may_run), .ready(ready),
   .coll(coll), .irq(irq), .irq_en(ctrl.irq_en)
);

// File: tb/byte_spi_master_tb.sv
`timescale 1ns/1ps
module byte_spi_master_tb;
   logic clk = 1'b0, rst_n = 1'b0;
   logic cs = 0, wr = 0, rd = 0, miso = 0;
   logic [2:0] addr = '0;
   logic [7:0] wdata = '0, rdata;
   logic irq, sck, mosi, mosi_oe;
   int n_chk = 0, n_fail = 0, cyc = 0, t_prev = 0, hp_last = 0;
   logic [7:0] s_sh, s_rx;
   logic s_cpol = 0, s_cpha = 0;
   int s_edges = 0;

   always #2.5 clk = ~clk;
   always @(posedge clk) cyc++;

   byte_spi_master u_dut (.clk(clk), .rst_n(rst_n), .cs(cs), .wr(wr), .rd(rd),
      .addr(addr), .wdata(wdata), .rdata(rdata), .irq(irq), .sck(sck),
      .mosi(mosi), .mosi_oe(mosi_oe), .miso(miso));

   // slave model
   always @(sck) begin
      if (sck !== s_cpol) begin
         if (!s_cpha) s_rx = {s_rx[6:0], mosi};
         else begin miso = s_sh[7]; s_sh = {s_sh[6:0], 1'b0}; end
      end else begin
         if (!s_cpha) begin miso = s_sh[7]; s_sh = {s_sh[6:0], 1'b0}; end
         else s_rx = {s_rx[6:0], mosi};
      end
      s_edges++;
      hp_last = cyc - t_prev;
      t_prev  = cyc;
   end

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic bus_write(input logic [2:0] a, input logic [7:0] d);
      @(negedge clk); cs = 1; wr = 1; addr = a; wdata = d;
      @(negedge clk); cs = 0; wr = 0;
   endtask

   task automatic bus_read(input logic [2:0] a, output logic [7:0] d);
      @(negedge clk); cs = 1; rd = 1; addr = a;
      #1 d = rdata;
      @(negedge clk); cs = 0; rd = 0;
   endtask

   task automatic slave_prep(input logic cpol, input logic cpha, input logic [7:0] sb);
      s_cpol = cpol; s_cpha = cpha; s_rx = 0; s_edges = 0; s_sh = sb;
      if (!cpha) begin miso = sb[7]; s_sh = {sb[6:0], 1'b0}; end
   endtask

   task automatic wait_irq(input string tag);
      for (int i = 0; i < 20000; i++) begin
         @(negedge clk);
         if (irq) break;
      end
      chk(irq === 1'b1, tag, irq, 1);
   endtask

   // ctrl: bit0 irq_en, bit1 master, bit2 sck_en, bit3 cpol, bit4 cpha
   task automatic xfer(input logic [7:0] ctrlv, input logic [7:0] prev,
                       input logic [7:0] mb, input logic [7:0] sb, input string tag);
      logic [7:0] d;
      bus_write(3, prev);
      bus_write(0, ctrlv);
      slave_prep(ctrlv[3], ctrlv[4], sb);
      bus_write(4, mb);
      wait_irq({tag, " irq"});
      chk(s_rx == mb, {tag, " slave got MOSI byte"}, s_rx, mb);
      bus_read(5, d);
      chk(d == sb, {tag, " rx register"}, d, sb);
      chk(s_edges == 16, {tag, " 16 SCK edges"}, s_edges, 16);
      chk(sck == ctrlv[3], {tag, " SCK idle at CPOL"}, sck, ctrlv[3]);
      bus_read(1, d);
      chk(d[0] == 1'b1, {tag, " ready set"}, d, 1);
   endtask

   task automatic t_reset;
      logic [7:0] d;
      bus_read(3, d); chk(d == 8'hFF, "R1 prescaler reset", d, 8'hFF);
      bus_read(0, d); chk(d == 0, "R1 ctrl reset", d, 0);
      bus_read(2, d); chk(d == 0, "R1 pinctl reset", d, 0);
      bus_read(1, d); chk(d == 0, "R1 status reset", d, 0);
      bus_read(5, d); chk(d == 0, "R1 rx reset", d, 0);
      chk(sck == 0 && irq == 0 && mosi_oe == 0, "R1 pins reset", {sck, irq, mosi_oe}, 0);
   endtask

   task automatic t_modes;
      xfer(8'h07, 8'h00, 8'hA5, 8'h3C, "R3 mode0");
      xfer(8'h17, 8'h01, 8'h96, 8'hE1, "R4 mode1");
      xfer(8'h0F, 8'h00, 8'h81, 8'h7E, "R5 mode2");
      xfer(8'h1F, 8'h02, 8'h5A, 8'hC3, "R5 mode3");
      chk(hp_last == 3, "R2 half period pre=2", hp_last, 3);
      xfer(8'h07, 8'h04, 8'h01, 8'hFF, "R2 pre=4");
      chk(hp_last == 5, "R2 half period pre=4", hp_last, 5);
   endtask

   task automatic t_irq_mode;
      logic [7:0] d;
      xfer(8'h07, 8'h00, 8'h11, 8'h22, "R6 irq on");
      bus_write(0, 8'h06);
      slave_prep(0, 0, 8'h44);
      bus_write(4, 8'h33);
      repeat (40) @(negedge clk);
      chk(irq == 0, "R6 irq off after completion", irq, 0);
      bus_read(1, d);
      chk(d[0] == 1, "R6 ready without irq mode", d, 1);
   endtask

   task automatic t_same_cycle;
      logic [7:0] d;
      bus_write(3, 0);
      bus_write(0, 8'h07);
      slave_prep(0, 0, 8'h55);
      bus_write(4, 8'hAA);
      repeat (15) @(posedge clk);
      bus_read(1, d);
      chk(d == 8'h04, "R7 status at completion cycle", d, 8'h04);
      bus_read(1, d);
      chk(d[0] == 1, "R7 completion wins over clear", d, 1);
      bus_read(1, d);
      chk(d == 0, "R7 status read clears", d, 0);
   endtask

   task automatic t_collision;
      logic [7:0] d;
      bus_write(3, 3);
      bus_write(0, 8'h07);
      slave_prep(0, 0, 8'h69);
      bus_write(4, 8'hC5);
      repeat (10) @(negedge clk);
      bus_write(4, 8'h3C);
      wait_irq("R8 irq");
      chk(s_rx == 8'hC5, "R8 original byte sent", s_rx, 8'hC5);
      chk(s_edges == 16, "R8 no restart", s_edges, 16);
      bus_read(5, d); chk(d == 8'h69, "R8 rx intact", d, 8'h69);
      bus_read(1, d); chk(d[1:0] == 2'b11, "R8 collision+ready", d, 3);
      bus_read(1, d); chk(d[1:0] == 2'b00, "R7 collision cleared", d, 0);
   endtask

   task automatic t_norun;
      logic [7:0] d;
      bus_write(0, 8'h0B);  // sck_en clear, cpol=1
      slave_prep(1, 0, 8'h00);
      bus_write(4, 8'h77);
      repeat (30) @(negedge clk);
      chk(sck == 1 && s_edges == 0, "R9 no SCK when disabled", s_edges, 0);
      bus_read(1, d); chk(d == 0, "R9 status idle sck_en=0", d, 0);
      bus_write(0, 8'h05);  // master clear
      slave_prep(0, 0, 8'h00);
      bus_write(4, 8'h77);
      repeat (30) @(negedge clk);
      bus_read(1, d); chk(d == 0 && s_edges == 0, "R9 status idle master=0", d, 0);
   endtask

   task automatic t_keep_and_clear;
      bus_write(2, 0);
      xfer(8'h07, 8'h00, 8'hA7, 8'h00, "R10 keep off");
      chk(mosi_oe == 0, "R10 oe released", mosi_oe, 0);
      bus_write(2, 1);
      xfer(8'h17, 8'h00, 8'h5B, 8'h00, "R10 keep on");
      chk(mosi_oe == 1 && mosi == 1'b1, "R10 mosi held at last bit", {mosi_oe, mosi}, 3);
      bus_write(2, 0);
      bus_write(0, 8'h07);
      slave_prep(0, 0, 8'h12);
      bus_write(4, 8'h34);
      wait_irq("R11 first irq");
      slave_prep(0, 0, 8'h56);
      bus_write(4, 8'h78);
      chk(irq == 0, "R11 tx write clears ready", irq, 0);
      wait_irq("R11 second irq");
      chk(s_rx == 8'h78, "R11 second byte", s_rx, 8'h78);
   endtask

   initial begin
      repeat (4) @(negedge clk);
      rst_n = 1;
      t_reset();
      t_modes();
      t_irq_mode();
      t_same_cycle();
      t_collision();
      t_norun();
      t_keep_and_clear();
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
   end
endmodule